// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs bus cycles on an external bus that carries both the address and the data over one set of shared pins. An internal requester gives it an address, write data, a read/write flag and a memory/I-O space flag. The sequencer then steps through four base states, T1 to T4. Each state lasts two system clocks. In T1 the address is on the shared pins, and the address-latch strobe pulses high for the first clock only, so its falling edge in the middle of T1 lets external logic latch the address. From T2 on, the pins either carry write data or are released so that a target can drive read data.

The target can stretch a cycle through an active-high ready input. The sequencer samples ready once, at the clock edge in the middle of T2, which is one clock before T3 starts. If ready is low there, two-clock wait states follow T3. During each wait state, ready is sampled again at its middle edge, and the sequencer leaves the wait states as soon as that sample is high. Read data is captured on the edge that starts T4. A one-clock done pulse in the last clock of T4 hands the data back to the requester. A new request is taken only while the sequencer is idle.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset and whenever idle, chip select, read, write, memory and I/O strobes (all active low) are high, the address-latch strobe is low, the pin output enable is low, and req_ready is high.
- R2: T1 lasts two clocks starting the cycle after acceptance: chip select low, the address-latch strobe high in the first clock and low in the second, and the request address driven with the output enable high.
- R3: In T2 the address leaves the pins. On a read the output enable is low and the read strobe is low. On a write the write data is driven and the write strobe is low. The read and write strobes are never low together.
- R4: From T2 to the end of T4, exactly one space strobe is low: the memory strobe when req_io=0, the I/O strobe when req_io=1. Neither is low in T1 or when idle.
- R5: T3 lasts two clocks, and every bus output during T3 equals its value in T2.
- R6: If bus_ready is low at the edge in the middle of T2, wait states follow T3. Each wait state lasts two clocks with the same outputs as T3. Another wait state follows whenever bus_ready is low at the middle edge of the current one. A high sample at the middle of T2 gives no wait states.
- R7: On a read, bus_ad_in is captured at the clock edge that starts T4, and the read strobe is high throughout T4.
- R8: On a write, the write strobe is high throughout T4, while chip select, the space strobe and the driven write data hold through the end of T4.
- R9: rsp_done is high for exactly the second clock of T4 and never otherwise. On a read, rsp_rdata then holds the captured value.
- R10: req_valid is accepted only while req_ready is high. Request inputs that change or stay asserted during a cycle do not affect that cycle's pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_addr | input | AD_W | Request address |
| req_wdata | input | AD_W | Write data |
| req_ready | output | 1 | High when idle and able to accept |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | AD_W | Captured read data |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ale | output | 1 | Address-latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_mreq_n | output | 1 | Memory-space strobe, active low |
| bus_iorq_n | output | 1 | I/O-space strobe, active low |
| bus_ad_out | output | AD_W | Value driven onto the shared pins |
| bus_ad_oe | output | 1 | Tri-state enable for the shared pins |
| bus_ad_in | input | AD_W | Value sampled from the shared pins |
| bus_ready | input | 1 | Target ready, low requests wait states |

## Verification
The pins are decoded directly from the slot and half-clock registers, so a wrong slot or phase shows at the pins in the same clock. A stuck phase bit doubles or halves the address-latch pulse within T1. A stale wait flag adds or drops two clocks before T4, and that shifts the done pulse and the capture edge, so the read data comes back wrong on that same transaction. A request latch that reloads while busy shows up as a changed address or write data on the pins within one clock of the disturbing input.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_T1   = 3'd1,
    S_T2   = 3'd2,
    S_T3   = 3'd3,
    S_TW   = 3'd4,
    S_T4   = 3'd5
  } bus_slot_e;

  // Slot that follows the current one at the end of its second clock.
  function automatic bus_slot_e next_slot(bus_slot_e s, logic stretch);
    bus_slot_e n;
    unique case (s)
      S_T1:        n = S_T2;
      S_T2:        n = S_T3;
      S_T3, S_TW:  n = stretch ? S_TW : S_T4;
      default:     n = S_IDLE;
    endcase
    return n;
  endfunction

  // Edges where the ready input is sampled: middle of T2 and of each wait.
  function automatic logic is_ready_sample(bus_slot_e s, logic ph);
    return (s == S_T2 || s == S_TW) && !ph;
  endfunction

  // Slots where the requester's strobe (read or write) is active.
  function automatic logic in_strobe_window(bus_slot_e s);
    return s == S_T2 || s == S_T3 || s == S_TW;
  endfunction

  // Slots where the space strobe is active.
  function automatic logic in_space_window(bus_slot_e s);
    return s == S_T2 || s == S_T3 || s == S_TW || s == S_T4;
  endfunction

endpackage

// File: rtl/mbs_slot_fsm.sv
module mbs_slot_fsm
  import mbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      bus_ready,
  output bus_slot_e slot,
  output logic      ph,
  output logic      ev_enter_t4,
  output logic      ev_done
);

  logic stretch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= S_IDLE;
      ph      <= 1'b0;
      stretch <= 1'b0;
    end else if (slot == S_IDLE) begin
      ph      <= 1'b0;
      stretch <= 1'b0;
      if (start) slot <= S_T1;
    end else begin
      ph <= ~ph;
      if (is_ready_sample(slot, ph)) stretch <= ~bus_ready;
      if (ph) slot <= next_slot(slot, stretch);
    end
  end

  assign ev_enter_t4 = ph && (slot == S_T3 || slot == S_TW) && !stretch;
  assign ev_done     = ph && (slot == S_T4);

endmodule

// File: rtl/mbs_req_latch.sv
module mbs_req_latch #(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            capture,
  input  logic            req_write,
  input  logic            req_io,
  input  logic [AD_W-1:0] req_addr,
  input  logic [AD_W-1:0] req_wdata,
  input  logic [AD_W-1:0] bus_ad_in,
  output logic            lat_write,
  output logic            lat_io,
  output logic [AD_W-1:0] lat_addr,
  output logic [AD_W-1:0] lat_wdata,
  output logic [AD_W-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_write <= 1'b0;
      lat_io    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (load) begin
        lat_write <= req_write;
        lat_io    <= req_io;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      if (capture && !lat_write) rdata <= bus_ad_in;
    end
  end

endmodule

// File: rtl/mbs_pin_drv.sv
module mbs_pin_drv
  import mbs_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  bus_slot_e       slot,
  input  logic            ph,
  input  logic            lat_write,
  input  logic            lat_io,
  input  logic [AD_W-1:0] lat_addr,
  input  logic [AD_W-1:0] lat_wdata,
  output logic            bus_cs_n,
  output logic            bus_ale,
  output logic            bus_rd_n,
  output logic            bus_wr_n,
  output logic            bus_mreq_n,
  output logic            bus_iorq_n,
  output logic [AD_W-1:0] bus_ad_out,
  output logic            bus_ad_oe
);

  logic addr_phase, strobe_win, space_win, data_phase;

  always_comb begin
    addr_phase = (slot == S_T1);
    strobe_win = in_strobe_window(slot);
    space_win  = in_space_window(slot);
    data_phase = lat_write && space_win;

    bus_cs_n   = (slot == S_IDLE);
    bus_ale    = addr_phase && !ph;
    bus_rd_n   = !(strobe_win && !lat_write);
    bus_wr_n   = !(strobe_win && lat_write);
    bus_mreq_n = !(space_win && !lat_io);
    bus_iorq_n = !(space_win && lat_io);
    bus_ad_oe  = addr_phase || data_phase;
    if (addr_phase)      bus_ad_out = lat_addr;
    else if (data_phase) bus_ad_out = lat_wdata;
    else                 bus_ad_out = '0;
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_io,
  input  logic [AD_W-1:0] req_addr,
  input  logic [AD_W-1:0] req_wdata,
  output logic            req_ready,
  output logic            rsp_done,
  output logic [AD_W-1:0] rsp_rdata,
  output logic            bus_cs_n,
  output logic            bus_ale,
  output logic            bus_rd_n,
  output logic            bus_wr_n,
  output logic            bus_mreq_n,
  output logic            bus_iorq_n,
  output logic [AD_W-1:0] bus_ad_out,
  output logic            bus_ad_oe,
  input  logic [AD_W-1:0] bus_ad_in,
  input  logic            bus_ready
);

  bus_slot_e       slot;
  logic            ph;
  logic            ev_accept, ev_enter_t4, ev_done;
  logic            lat_write, lat_io;
  logic [AD_W-1:0] lat_addr, lat_wdata;

  assign req_ready = (slot == S_IDLE);
  assign ev_accept = req_ready && req_valid;
  assign rsp_done  = ev_done;

  mbs_slot_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ev_accept),
    .bus_ready   (bus_ready),
    .slot        (slot),
    .ph          (ph),
    .ev_enter_t4 (ev_enter_t4),
    .ev_done     (ev_done)
  );

  mbs_req_latch #(.AD_W(AD_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .capture   (ev_enter_t4),
    .req_write (req_write),
    .req_io    (req_io),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .bus_ad_in (bus_ad_in),
    .lat_write (lat_write),
    .lat_io    (lat_io),
    .lat_addr  (lat_addr),
    .lat_wdata (lat_wdata),
    .rdata     (rsp_rdata)
  );

  mbs_pin_drv #(.AD_W(AD_W)) u_pins (
    .slot       (slot),
    .ph         (ph),
    .lat_write  (lat_write),
    .lat_io     (lat_io),
    .lat_addr   (lat_addr),
    .lat_wdata  (lat_wdata),
    .bus_cs_n   (bus_cs_n),
    .bus_ale    (bus_ale),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_mreq_n (bus_mreq_n),
    .bus_iorq_n (bus_iorq_n),
    .bus_ad_out (bus_ad_out),
    .bus_ad_oe  (bus_ad_oe)
  );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
  input logic clk,
  input logic rst_n,
  input logic ev_accept,
  input logic ev_done,
  input logic req_ready,
  input logic bus_cs_n,
  input logic bus_ale,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic bus_mreq_n,
  input logic bus_iorq_n,
  input logic bus_ad_oe
);

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_cs_n && bus_rd_n && bus_wr_n && bus_mreq_n && bus_iorq_n && !bus_ad_oe && !bus_ale)); // R1
  AST_ACCEPT_T1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (!bus_cs_n && bus_ale && bus_ad_oe)); // R2
  AST_ALE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |=> !bus_ale); // R2
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)); // R3
  AST_NO_READ_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe); // R3
  AST_ONE_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~bus_mreq_n, ~bus_iorq_n}) <= 1); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> (!ev_done && req_ready)); // R9
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !ev_accept); // R10

endmodule

bind mux_bus_seq mbs_checker u_mbs_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_accept  (ev_accept),
  .ev_done    (ev_done),
  .req_ready  (req_ready),
  .bus_cs_n   (bus_cs_n),
  .bus_ale    (bus_ale),
  .bus_rd_n   (bus_rd_n),
  .bus_wr_n   (bus_wr_n),
  .bus_mreq_n (bus_mreq_n),
  .bus_iorq_n (bus_iorq_n),
  .bus_ad_oe  (bus_ad_oe)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;

  localparam int AD_W = 16;
  localparam int NV   = 7;
  // vector: [41] write, [40] io, [39:24] addr, [23:8] wdata, [7:0] ready-low length
  localparam logic [41:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h1234, 16'h0000, 8'd0},
    {1'b1, 1'b0, 16'hBEEF, 16'h5A5A, 8'd0},
    {1'b0, 1'b1, 16'h00F0, 16'h0000, 8'd2},
    {1'b1, 1'b1, 16'h8001, 16'hC3C3, 8'd3},
    {1'b0, 1'b0, 16'h7777, 16'h0000, 8'd7},
    {1'b1, 1'b0, 16'h4242, 16'h0F0F, 8'd12},
    {1'b0, 1'b1, 16'hFFFF, 16'h0000, 8'd6}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [AD_W-1:0] req_addr = '0, req_wdata = '0, bus_ad_in = '0;
  logic            bus_ready = 1'b1;
  logic            req_ready, rsp_done, bus_cs_n, bus_ale, bus_rd_n, bus_wr_n;
  logic            bus_mreq_n, bus_iorq_n, bus_ad_oe;
  logic [AD_W-1:0] rsp_rdata, bus_ad_out;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mux_bus_seq #(.AD_W(AD_W)) i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_cs_n(bus_cs_n), .bus_ale(bus_ale), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_mreq_n(bus_mreq_n), .bus_iorq_n(bus_iorq_n),
    .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
    .bus_ready(bus_ready)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // pins packed as {ready, done, cs_n, ale, rd_n, wr_n, oe, ad_out}
  function automatic logic [63:0] pins_now();
    return {41'd0, req_ready, rsp_done, bus_cs_n, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, bus_ad_out};
  endfunction

  // wait states from the length of the low stretch on ready
  function automatic int waits_for(int low_len);
    int w = 0;
    if (low_len > 2) begin
      w = 1;
      while (6 + 2 * (w - 1) < low_len) w++;
    end
    return w;
  endfunction

  task automatic run_txn(input logic w, input logic io, input logic [AD_W-1:0] a,
                         input logic [AD_W-1:0] d, input int low_len, input bit noise);
    int nw = waits_for(low_len);
    int last = 7 + 2 * nw;
    logic [AD_W-1:0] rdv = a ^ 16'hA5C3;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_io = io; req_addr = a; req_wdata = d;
    bus_ready = 1'b1;
    for (int c = 0; c <= last + 1; c++) begin
      int slot;
      bit t1, t2, t3, tw, t4, idle, stw, spw, e_oe;
      logic [AD_W-1:0] e_out;
      string tag;
      @(negedge clk);
      slot = c / 2;
      t1 = (slot == 0); t2 = (slot == 1); t3 = (slot == 2);
      tw = (slot >= 3 && slot < 3 + nw); t4 = (slot == 3 + nw); idle = (c > last);
      stw = t2 || t3 || tw; spw = stw || t4;
      e_oe = t1 || (w && spw);
      e_out = t1 ? a : ((w && spw) ? d : '0);
      tag = t1 ? "R2" : t2 ? "R3" : t3 ? "R5" : tw ? "R6" : t4 ? (w ? "R8" : "R7") : "R10";
      check(tag, pins_now(),
            {41'd0, idle, (t4 && c[0]), idle, (t1 && !c[0]), !(stw && !w), !(stw && w), e_oe, e_out});
      check("R4", {62'd0, bus_mreq_n, bus_iorq_n}, {62'd0, !(spw && !io), !(spw && io)});
      if (c == last && !w) check("R9", rsp_rdata, rdv);
      bus_ready = (c >= low_len);
      bus_ad_in = (c == 5 + 2 * nw) ? rdv : ~rdv;
      if (noise) begin
        req_addr = a ^ AD_W'(c + 1); req_wdata = d ^ AD_W'(3 * c + 1); req_io = ~io;
        req_valid = (c < last);
      end else begin
        req_valid = 1'b0;
      end
    end
    req_io = io;
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", pins_now(), {41'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0});
    check("R1 reset", {62'd0, bus_mreq_n, bus_iorq_n}, 64'd3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", pins_now(), {41'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0});

    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][41], VEC[i][40], VEC[i][39:24], VEC[i][23:8], int'(VEC[i][7:0]), 1'b0);

    // R10: request inputs churn and valid stays high during a cycle
    run_txn(1'b1, 1'b0, 16'h2468, 16'h1357, 4, 1'b1);
    run_txn(1'b0, 1'b1, 16'h0AA0, 16'h0000, 0, 1'b1);

    // R1: reset in the middle of a cycle returns the pins to idle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h9999; req_wdata = 16'h6666;
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 midreset", pins_now(), {41'd0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0});
    @(negedge clk); rst_n = 1'b1;
    run_txn(1'b0, 1'b0, 16'h0102, 16'h0000, 5, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule